// File: doc/BRIEF.md
# Glitch-Free Base Clock Selector with Divide-by-Four Chain

This block chooses the clock that feeds a chip's clocking tree. It takes the free-running oscillator clock and the output of a PLL oscillator. A request bit asks for the PLL clock. The block honours that request only while the PLL is switched on and its range setting is non-zero. In every other case it stays on the oscillator, or falls back to it.

Changing source is done as a handshake between the two clock domains. The old clock is gated off on its falling edge, and only then is the new clock gated on, also on a falling edge. The selected clock is halved to give the module clock. The module clock is halved again to give the bus clock, so the bus runs at one quarter of the chosen source. A status output reports the PLL as the active source only once the handover has fully completed.

The control state machine runs on the oscillator clock and has four states:
- `SW_OSC`: oscillator active.
- `SW_ARM`: PLL requested, waiting for the PLL gate to open.
- `SW_VCO`: PLL active.
- `SW_BACK`: returning to the oscillator.

Its transitions are:
- `SW_OSC -> SW_ARM` when the request is valid.
- `SW_ARM -> SW_VCO` once the PLL gate is seen open.
- `SW_ARM -> SW_BACK` or `SW_VCO -> SW_BACK` as soon as the request becomes invalid.
- `SW_BACK -> SW_OSC` once the PLL gate is seen closed and the oscillator gate is open.

Top module: `clkbase_switch`

## Requirements
- R1: While `rst_n` is low, `sel_active`, `mod_clk` and `bus_clk` are all 0.
- R2: With `sel_req` at 0, `sel_active` is 0 and `bus_clk` has a period of four oscillator periods.
- R3: With `sel_req`, `pll_on` at 1 and `range_zero` at 0, `sel_active` becomes 1 and `bus_clk` has a period of four VCO periods.
- R4: `mod_clk` has twice the period of the selected source clock.
- R5: `bus_clk` toggles on every rising edge of `mod_clk`.
- R6: A request with `pll_on` at 0 is ignored: `sel_active` stays 0 and the bus keeps the oscillator rate.
- R7: `range_zero` at 1 drops the PLL selection: one oscillator cycle later `sel_active` is 0, and the bus returns to the oscillator rate.
- R8: `pll_on` falling while the PLL is active drops the selection back to the oscillator.
- R9: The two clock gates are never open together, and no high or low phase of `mod_clk` is shorter than the shorter source period.
- R10: `sel_active` rises only after the PLL gate is open, and never in the first oscillator cycle after a valid request.
- R11: Removing `sel_req` returns the bus to the oscillator rate, with `sel_active` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Free-running oscillator clock, also clocks the control FSM |
| vco_clk | input | 1 | PLL oscillator clock |
| sel_req | input | 1 | Request to use the PLL clock as base clock |
| pll_on | input | 1 | PLL is enabled |
| range_zero | input | 1 | PLL range setting is zero (PLL unusable) |
| mod_clk | output | 1 | Selected clock divided by 2 |
| bus_clk | output | 1 | Selected clock divided by 4 |
| sel_active | output | 1 | 1 when the PLL clock drives the outputs after a finished handover |

## Verification
The assertions assume that `osc_clk` never stops, since it clocks the controller and the feedback synchronizer. They also assume that `vco_clk` keeps running whenever a PLL selection is requested or being withdrawn. Without it, the PLL gate cannot open or close and the handover would stall. The stimulus keeps both clocks running throughout and changes control inputs only just after an oscillator falling edge. Every new setting is held for many tens of oscillator cycles, so each handover finishes before the next change.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    typedef enum logic [1:0] {
        SW_OSC  = 2'd0,
        SW_ARM  = 2'd1,
        SW_VCO  = 2'd2,
        SW_BACK = 2'd3
    } sw_state_e;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
module clksel_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_gate.sv
`timescale 1ns/1ps
module clksel_gate #(
    parameter int STAGES = 2,
    parameter bit RST_ON = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic en
);
    logic arm_s;

    clksel_sync #(.STAGES(STAGES), .RST_VAL(RST_ON)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (arm),
        .q    (arm_s)
    );

    // Enable changes only while the clock is low, so no partial pulse.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en <= RST_ON;
        else        en <= arm_s;
    end
endmodule

// File: rtl/clksel_div2.sv
`timescale 1ns/1ps
module clksel_div2 (
    input  logic clk,
    input  logic rst_n,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ~q;
    end
endmodule

// File: rtl/clkbase_switch.sv
`timescale 1ns/1ps
module clkbase_switch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic rst_n,
    input  logic osc_clk,
    input  logic vco_clk,
    input  logic sel_req,
    input  logic pll_on,
    input  logic range_zero,
    output logic mod_clk,
    output logic bus_clk,
    output logic sel_active
);
    import clksel_pkg::*;

    sw_state_e state_q, state_d;
    logic      want_vco;
    logic      go;
    logic      osc_en, vco_en, vco_fb;
    logic      base_clk;

    assign go = sel_req & pll_on & ~range_zero;

    // Oscillator-side gate: open only when PLL not wanted and PLL gate shut.
    clksel_gate #(.STAGES(SYNC_STAGES), .RST_ON(1'b1)) u_gate_osc (
        .clk  (osc_clk),
        .rst_n(rst_n),
        .arm  (~want_vco & ~vco_en),
        .en   (osc_en)
    );

    // PLL-side gate: open only when PLL wanted and oscillator gate shut.
    clksel_gate #(.STAGES(SYNC_STAGES), .RST_ON(1'b0)) u_gate_vco (
        .clk  (vco_clk),
        .rst_n(rst_n),
        .arm  (want_vco & ~osc_en),
        .en   (vco_en)
    );

    // Feedback of the PLL gate into the controller domain.
    clksel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_fb (
        .clk  (osc_clk),
        .rst_n(rst_n),
        .d    (vco_en),
        .q    (vco_fb)
    );

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_OSC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_OSC:  if (go) state_d = SW_ARM;
            SW_ARM:  if (!go) state_d = SW_BACK;
                     else if (vco_fb) state_d = SW_VCO;
            SW_VCO:  if (!go) state_d = SW_BACK;
            SW_BACK: if (!vco_fb && osc_en) state_d = SW_OSC;
        endcase
    end

    always_comb begin
        want_vco   = 1'b0;
        sel_active = 1'b0;
        unique case (state_q)
            SW_OSC:  ;
            SW_ARM:  want_vco = 1'b1;
            SW_VCO:  begin
                         want_vco   = 1'b1;
                         sel_active = 1'b1;
                     end
            SW_BACK: ;
        endcase
    end

    assign base_clk = (osc_clk & osc_en) | (vco_clk & vco_en);

    clksel_div2 u_div_mod (
        .clk  (base_clk),
        .rst_n(rst_n),
        .q    (mod_clk)
    );

    clksel_div2 u_div_bus (
        .clk  (mod_clk),
        .rst_n(rst_n),
        .q    (bus_clk)
    );
endmodule

// File: rtl/clkbase_switch_chk.sv
`timescale 1ns/1ps
module clkbase_switch_chk (
    input logic rst_n,
    input logic osc_clk,
    input logic mod_clk,
    input logic bus_clk,
    input logic sel_req,
    input logic pll_on,
    input logic range_zero,
    input logic sel_active,
    input logic osc_en,
    input logic vco_en,
    input logic vco_fb
);
    assert_gates_exclusive_R9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $onehot0({osc_en, vco_en}));

    assert_active_after_handover_R10: assert property (@(posedge osc_clk) disable iff (!rst_n)
        sel_active |-> vco_fb);

    assert_pll_off_blocks_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !pll_on |=> !sel_active);

    assert_range_zero_drops_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
        range_zero |=> !sel_active);

    assert_no_request_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !sel_req |=> !sel_active);

    assert_bus_toggles_R5: assert property (@(posedge mod_clk) disable iff (!rst_n)
        1'b1 |=> (bus_clk != $past(bus_clk)));
endmodule

bind clkbase_switch clkbase_switch_chk u_chk (
    .rst_n     (rst_n),
    .osc_clk   (osc_clk),
    .mod_clk   (mod_clk),
    .bus_clk   (bus_clk),
    .sel_req   (sel_req),
    .pll_on    (pll_on),
    .range_zero(range_zero),
    .sel_active(sel_active),
    .osc_en    (osc_en),
    .vco_en    (vco_en),
    .vco_fb    (vco_fb)
);

// File: tb/clkbase_switch_bench.sv
`timescale 1ns/1ps
module clkbase_switch_bench;
    localparam real OSC_P = 5.0;
    localparam real VCO_P = 3.0;

    logic rst_n = 1'b0;
    logic osc_clk = 1'b0;
    logic vco_clk = 1'b0;
    logic sel_req = 1'b0;
    logic pll_on = 1'b0;
    logic range_zero = 1'b0;
    logic mod_clk, bus_clk, sel_active;

    int checks = 0;
    int fails  = 0;
    int runts  = 0;
    int issued = 0;
    int served = 0;
    bit ended  = 1'b0;

    typedef struct {
        string tag;
        bit    sel;
        real   src_p;
    } exp_t;
    exp_t q[$];

    always #(OSC_P / 2.0) osc_clk = ~osc_clk;
    always #(VCO_P / 2.0) vco_clk = ~vco_clk;

    clkbase_switch u_clkbase_switch (
        .rst_n     (rst_n),
        .osc_clk   (osc_clk),
        .vco_clk   (vco_clk),
        .sel_req   (sel_req),
        .pll_on    (pll_on),
        .range_zero(range_zero),
        .mod_clk   (mod_clk),
        .bus_clk   (bus_clk),
        .sel_active(sel_active)
    );

    task automatic check(string tag, bit ok, string act, string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    function automatic bit near(real a, real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    // Driver: queue an expected steady state and wait for the monitor.
    task automatic expect_state(string tag, bit sel, real src_p);
        exp_t e;
        e.tag = tag; e.sel = sel; e.src_p = src_p;
        q.push_back(e);
        issued++;
        wait (served == issued);
    endtask

    task automatic osc_cycles(int n);
        repeat (n) @(posedge osc_clk);
        @(negedge osc_clk);
    endtask

    // Monitor: measure periods and status for each queued item.
    initial begin
        forever begin
            exp_t e;
            real  b1, b2, m1, m2;
            wait (issued > served);
            e = q.pop_front();
            @(posedge bus_clk); b1 = $realtime;
            @(posedge bus_clk); b2 = $realtime;
            @(posedge mod_clk); m1 = $realtime;
            @(posedge mod_clk); m2 = $realtime;
            #0.5;
            check({e.tag, " sel_active"}, sel_active == e.sel,
                  $sformatf("%0b", sel_active), $sformatf("%0b", e.sel));
            check({e.tag, " bus period (R5)"}, near(b2 - b1, 4.0 * e.src_p),
                  $sformatf("%0.2f", b2 - b1), $sformatf("%0.2f", 4.0 * e.src_p));
            check({e.tag, " mod period (R4)"}, near(m2 - m1, 2.0 * e.src_p),
                  $sformatf("%0.2f", m2 - m1), $sformatf("%0.2f", 2.0 * e.src_p));
            served++;
        end
    end

    // Runt detector for R9: every mod_clk phase spans at least one base period.
    real last_edge = -1.0;
    always @(mod_clk) begin
        if (rst_n && last_edge >= 0.0 && ($realtime - last_edge) < VCO_P - 0.1)
            runts++;
        last_edge = $realtime;
    end

    initial begin
        #200000;
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #22;
        check("R1 reset sel_active", sel_active == 1'b0, $sformatf("%0b", sel_active), "0");
        check("R1 reset mod_clk", mod_clk == 1'b0, $sformatf("%0b", mod_clk), "0");
        check("R1 reset bus_clk", bus_clk == 1'b0, $sformatf("%0b", bus_clk), "0");
        #4 rst_n = 1'b1;
        osc_cycles(20);
        expect_state("R2 oscillator default", 1'b0, OSC_P);

        sel_req = 1'b1;
        osc_cycles(40);
        expect_state("R6 request with pll off", 1'b0, OSC_P);

        pll_on = 1'b1;
        @(posedge osc_clk); #1;
        check("R10 not active one cycle after request", sel_active == 1'b0,
              $sformatf("%0b", sel_active), "0");
        osc_cycles(40);
        expect_state("R3 switch to vco", 1'b1, VCO_P);

        range_zero = 1'b1;
        @(posedge osc_clk); #1;
        check("R7 status drops one cycle after range zero", sel_active == 1'b0,
              $sformatf("%0b", sel_active), "0");
        osc_cycles(40);
        expect_state("R7 range zero fallback", 1'b0, OSC_P);

        range_zero = 1'b0;
        osc_cycles(40);
        expect_state("R3 reselect vco", 1'b1, VCO_P);

        pll_on = 1'b0;
        osc_cycles(40);
        expect_state("R8 pll off fallback", 1'b0, OSC_P);

        pll_on = 1'b1;
        osc_cycles(40);
        expect_state("R3 vco after pll on", 1'b1, VCO_P);

        sel_req = 1'b0;
        osc_cycles(40);
        expect_state("R11 request removed", 1'b0, OSC_P);

        check("R9 no runt phase on mod_clk", runts == 0, $sformatf("%0d", runts), "0");

        ended = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule